// File: doc/BRIEF.md
# Configurable LUT Logic Cell

This block is a single programmable cell for a small fabric of programmable logic. Two 3-input lookup tables read the same three low data inputs. A programmed mode bit decides how their results are used. In logic mode, the fourth data input picks one of the two results, so the cell computes any function of four inputs. In arithmetic mode, the two results are the operand bits of a one-bit full adder, which takes its carry from the previous cell and passes a carry on to the next one.

A second programmed bit decides the output path. The cell output is either the combinational result or the value of a D flip-flop that captures that result on every rising clock edge. All programming is loaded through a serial shift port. The port's serial output lets many cells share one configuration chain.

Top module: `lcell`

## Requirements
- R1: While `rst_n` is low, the configuration word and the flip-flop are cleared. With a cleared word the cell is in logic mode with registered output, so `cell_out`, `carry_out` and `cfg_out` are 0.
- R2: On each rising edge with `cfg_en` high, the configuration word shifts one place and takes `cfg_in` at its low end. Bits go in MSB first: the 8-bit table of the low LUT, then the 8-bit table of the high LUT, then the mode bit (1 = arithmetic), then the output-path bit (1 = combinational). With `cfg_en` low the word holds.
- R3: `cfg_out` gives the bit that was shifted in 18 enabled shifts earlier, so cells can be chained.
- R4: Each LUT returns the table bit whose index is {data_in[2], data_in[1], data_in[0]}, with data_in[0] as the least significant bit.
- R5: In logic mode the result is the high LUT's bit when data_in[3] is 1 and the low LUT's bit when data_in[3] is 0, and `carry_out` is 0.
- R6: In arithmetic mode the result is the sum of the low LUT bit, the high LUT bit and `carry_in`, and `carry_out` is the carry of that sum.
- R7: With the output-path bit at 1, `cell_out` follows the result in the same cycle.
- R8: With the output-path bit at 0, `cell_out` is a register that takes the result on each rising edge after reset.
- R9: `rst_n` clears the cell at once, but its release is synchronised. The cell's registers stay cleared through the first two rising edges after `rst_n` goes high and work from the third.
- R10: In logic mode, `carry_in` has no effect on `cell_out` or `carry_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the cell |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_in | input | 1 | Serial configuration input |
| cfg_out | output | 1 | Serial configuration output to the next cell |
| data_in | input | 4 | LUT inputs; bit 3 selects between the LUTs in logic mode |
| carry_in | input | 1 | Carry from the previous cell |
| carry_out | output | 1 | Carry to the next cell |
| cell_out | output | 1 | Logic output, combinational or registered |

## Verification
The bench builds the cell with the default of three LUT inputs. That gives an 18-bit configuration word, so the bench can load a fresh random truth table in a few cycles. With that short load it covers all four settings of mode and output path many times, with random data and carry on every cycle. It also toggles the shift enable at random to show that the word holds when shifting stops. Reset is applied twice. Configuration bits shifted in during the release window show exactly which edge first changes state.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  localparam int unsigned LUT_K_DEF = 3;
  localparam int unsigned RST_STAGES_DEF = 2;

  typedef enum logic {
    MODE_LOGIC = 1'b0,
    MODE_ARITH = 1'b1
  } cell_mode_e;
endpackage

// File: rtl/lcell_rst_sync.sv
module lcell_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[STAGES-1];

  // R9: released output implies the raw reset was high one edge before
  assert_release_after_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n_sync |-> $past(rst_n));
endmodule

// File: rtl/lcell_cfg_chain.sv
module lcell_cfg_chain #(
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             ser_in,
  output logic             ser_out,
  output logic [WIDTH-1:0] word
);
  logic [WIDTH-1:0] sr_q;
  logic [WIDTH-1:0] sr_d;

  always_comb begin
    sr_d = sr_q;
    if (shift_en) sr_d = {sr_q[WIDTH-2:0], ser_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign word    = sr_q;
  assign ser_out = sr_q[WIDTH-1];

  assert_shift_takes_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (sr_q[0] == $past(ser_in)));

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sr_q));
endmodule

// File: rtl/lcell_lut.sv
module lcell_lut #(
  parameter int unsigned K = 3
) (
  input  logic [(1<<K)-1:0] truth_i,
  input  logic [K-1:0]      sel_i,
  output logic              out_o
);
  localparam int unsigned ENTRIES = 1 << K;

  // binary mux tree; level l has ENTRIES>>l nodes
  logic [ENTRIES-1:0] lvl [K+1];

  assign lvl[0] = truth_i;

  for (genvar l = 0; l < K; l++) begin : g_level
    localparam int unsigned NODES = ENTRIES >> (l + 1);
    for (genvar n = 0; n < NODES; n++) begin : g_node
      assign lvl[l+1][n] = sel_i[l] ? lvl[l][2*n+1] : lvl[l][2*n];
    end
    if (NODES < ENTRIES) begin : g_pad
      assign lvl[l+1][ENTRIES-1:NODES] = '0;
    end
  end

  assign out_o = lvl[K][0];
endmodule

// File: rtl/lcell_fa.sv
module lcell_fa (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic half;

  always_comb begin
    half = a_i ^ b_i;
    s_o  = half ^ c_i;
    c_o  = (a_i & b_i) | (half & c_i);
  end

  always_comb begin
    if (!$isunknown({a_i, b_i, c_i})) begin
      assert_fa_sum_R6: assert ({c_o, s_o} == (2'(a_i) + 2'(b_i) + 2'(c_i)));
    end
  end
endmodule

// File: rtl/lcell.sv
module lcell
  import lcell_pkg::*;
#(
  parameter int unsigned LUT_K      = LUT_K_DEF,
  parameter int unsigned RST_STAGES = RST_STAGES_DEF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_en,
  input  logic           cfg_in,
  output logic           cfg_out,
  input  logic [LUT_K:0] data_in,
  input  logic           carry_in,
  output logic           carry_out,
  output logic           cell_out
);
  localparam int unsigned LUT_BITS = 1 << LUT_K;
  localparam int unsigned CFG_BITS = 2 * LUT_BITS + 2;
  localparam int unsigned NUM_LUTS = 2;

  logic                rst_sync_n;
  logic [CFG_BITS-1:0] cfg_word;
  logic [LUT_BITS-1:0] lut_truth [NUM_LUTS];
  logic [NUM_LUTS-1:0] lut_res;
  cell_mode_e          mode;
  logic                comb_path;
  logic                fa_sum;
  logic                fa_carry;
  logic                logic_res;
  logic                q_d;
  logic                q_en;
  logic                q_r;

  lcell_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_sync_n)
  );

  lcell_cfg_chain #(.WIDTH(CFG_BITS)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .shift_en (cfg_en),
    .ser_in   (cfg_in),
    .ser_out  (cfg_out),
    .word     (cfg_word)
  );

  // first table shifted in sits at the top of the word
  assign lut_truth[0] = cfg_word[CFG_BITS-1 -: LUT_BITS];
  assign lut_truth[1] = cfg_word[2 +: LUT_BITS];
  assign mode         = cell_mode_e'(cfg_word[1]);
  assign comb_path    = cfg_word[0];

  for (genvar g = 0; g < NUM_LUTS; g++) begin : g_lut
    lcell_lut #(.K(LUT_K)) u_lut (
      .truth_i (lut_truth[g]),
      .sel_i   (data_in[LUT_K-1:0]),
      .out_o   (lut_res[g])
    );
  end

  lcell_fa u_fa (
    .a_i (lut_res[0]),
    .b_i (lut_res[1]),
    .c_i (carry_in),
    .s_o (fa_sum),
    .c_o (fa_carry)
  );

  always_comb begin
    if (mode == MODE_ARITH) begin
      logic_res = fa_sum;
      carry_out = fa_carry;
    end else begin
      logic_res = data_in[LUT_K] ? lut_res[1] : lut_res[0];
      carry_out = 1'b0;
    end
    q_en = 1'b1;
    q_d  = q_en ? logic_res : q_r;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) q_r <= 1'b0;
    else             q_r <= q_d;
  end

  assign cell_out = comb_path ? logic_res : q_r;

  assert_reg_follows_result_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (q_r == $past(logic_res)));

  assert_held_in_reset_R1: assert property (@(posedge clk)
    !rst_sync_n |-> (q_r == 1'b0 && cfg_out == 1'b0));
endmodule

// File: tb/lcell_test.sv
`timescale 1ns/1ps
module lcell_test;
  localparam int K  = 3;
  localparam int CW = 2 * (1 << K) + 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b0;
  logic       cfg_in = 1'b0;
  logic [3:0] data_in = '0;
  logic       carry_in = 1'b0;
  logic       cfg_out, carry_out, cell_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit rel_win = 0;

  // reference state
  logic          m_rs1 = 0, m_rs2 = 0;
  logic [CW-1:0] m_cfg = '0;
  logic          m_q = 0;

  always #10 clk = ~clk;

  lcell uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_in(cfg_in), .cfg_out(cfg_out),
    .data_in(data_in), .carry_in(carry_in), .carry_out(carry_out), .cell_out(cell_out)
  );

  // returns {carry, result}
  function automatic logic [1:0] ref_eval(input logic [CW-1:0] c, input logic [3:0] d,
                                          input logic ci);
    int idx;
    logic lo, hi;
    idx = int'(d[2:0]);
    lo = c[CW - (1 << K) + idx];
    hi = c[2 + idx];
    if (c[1]) return {(lo & hi) | (lo & ci) | (hi & ci), lo ^ hi ^ ci};
    return {1'b0, d[3] ? hi : lo};
  endfunction

  always @(posedge clk) begin
    logic [1:0] r;
    logic was_live;
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0; m_cfg = '0; m_q = 0;
    end else begin
      was_live = m_rs2;
      m_rs2 = m_rs1;
      m_rs1 = 1;
      if (was_live) begin
        r = ref_eval(m_cfg, data_in, carry_in);
        m_q = r[0];
        if (cfg_en) m_cfg = {m_cfg[CW-2:0], cfg_in};
      end
    end
  end

  task automatic check(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [1:0] r;
    logic exp_out;
    r = ref_eval(m_cfg, data_in, carry_in);
    exp_out = m_cfg[0] ? r[0] : m_q;
    if (!rst_n) begin
      check("R1 cell_out in reset", cell_out, 1'b0);
      check("R1 cfg_out in reset", cfg_out, 1'b0);
      check("R1 carry_out in reset", carry_out, 1'b0);
    end else begin
      check(rel_win ? "R9 cfg_out after release" : "R3 cfg_out chain", cfg_out, m_cfg[CW-1]);
      if (m_cfg[1]) check("R6 carry_out arithmetic", carry_out, r[1]);
      else check(carry_in ? "R10 carry_out ignores carry_in" : "R5 carry_out logic mode",
                 carry_out, 1'b0);
      if (m_cfg[0])
        check(m_cfg[1] ? "R7 R6 R4 R2 comb sum" : "R7 R5 R4 R2 R10 comb logic",
              cell_out, exp_out);
      else
        check(rel_win ? "R9 R8 registered" : "R8 R4 R2 registered", cell_out, exp_out);
    end
  end

  task automatic step(input logic en, input logic ci_bit);
    @(negedge clk);
    #2;
    cfg_en   = en;
    cfg_in   = ci_bit;
    data_in  = 4'($urandom);
    carry_in = 1'($urandom);
  endtask

  task automatic load(input logic [CW-1:0] w);
    for (int i = CW - 1; i >= 0; i--) step(1'b1, w[i]);
  endtask

  task automatic do_reset(input int cycles);
    @(negedge clk); #2; rst_n = 1'b0;
    for (int i = 0; i < cycles; i++) step(1'b0, 1'b0);
    @(negedge clk); #2; rst_n = 1'b1; rel_win = 1;
  endtask

  initial begin
    do_reset(3);
    // bits shifted during the release window: only those from the third edge land
    load({16'($urandom), 1'b0, 1'b1});
    load({16'($urandom), 1'b0, 1'b0});
    rel_win = 0;
    for (int m = 0; m < 2; m++)
      for (int b = 0; b < 2; b++)
        for (int rep = 0; rep < 4; rep++) begin
          load({16'($urandom), 1'(m), 1'(b)});
          for (int c = 0; c < 30; c++) step(1'b0, 1'b0);
        end
    // random shift enable: holding and partial shifts
    for (int c = 0; c < 80; c++) step(1'($urandom), 1'($urandom));
    do_reset(2);
    load({16'($urandom), 1'b1, 1'b0});
    rel_win = 0;
    for (int c = 0; c < 30; c++) step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule